// File: doc/BRIEF.md
# Low-Power Region Reuse Monitor

This block decides, for a whole cache, whether moving lines between the low-power way group and the high-power way group is paying off. It watches one stream of lookup outcomes: each cycle the placement controller may raise a lookup strobe together with a flag saying whether that lookup hit in the low-power group. One shared saturating counter steps up on every such hit and down on every such miss, so it follows the recent reuse seen in the low-power group.

When the count shows poor reuse, the block drops its migration-enable output and the cache runs like a conventional cache with no inter-region movement. The counter keeps following lookups while migration is off. Once the count climbs to the threshold plus a hysteresis margin, migration is switched back on. Threshold and hysteresis come from pins that are captured only while reset is held, so later changes on those pins have no effect until the next reset. The lookup interface is a plain per-cycle strobe and never back-pressures the controller: every strobed lookup is counted in the cycle it appears.

Top module: `reuse_monitor`

## Requirements
- R1: While reset (active-low `rst_n`, synchronous) is held, the counter loads mid-scale (16 for the 5-bit default), `mig_en` is 1, and `thr_cfg` and `hyst_cfg` are captured.
- R2: A cycle with `lookup_vld`=1 and `lp_hit`=1 raises the count by one at the next clock edge.
- R3: A cycle with `lookup_vld`=1 and `lp_hit`=0 lowers the count by one at the next clock edge.
- R4: The count saturates at its maximum (31): further hits leave it at 31.
- R5: The count saturates at 0: further misses leave it at 0.
- R6: While `mig_en` is 1, it becomes 0 one clock edge after the count is strictly below the captured threshold.
- R7: While `mig_en` is 0, it becomes 1 one clock edge after the count is at least threshold plus hysteresis (computed without wrap; a sum above 31 never re-enables); otherwise `mig_en` keeps its value.
- R8: The count keeps responding to hits and misses while `mig_en` is 0.
- R9: Changes on `thr_cfg` and `hyst_cfg` after reset is released have no effect on `mig_en`.
- R10: A cycle with `lookup_vld`=0 leaves the count unchanged, whatever `lp_hit` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration captured while low |
| lookup_vld | input | 1 | A cache lookup completed this cycle |
| lp_hit | input | 1 | That lookup hit in the low-power way group |
| thr_cfg | input | 5 | Disable threshold, sampled during reset |
| hyst_cfg | input | 5 | Re-enable margin above the threshold, sampled during reset |
| mig_en | output | 1 | Inter-region migration allowed |

## Verification
The bench builds the block with its default 5-bit counter and mid-scale start of 16, so both saturation limits lie within a few dozen lookups and are reached on purpose by long runs of hits and of misses. It resets with several threshold and hysteresis pairs, including a zero threshold that never disables, a sum above 31 that never re-enables, and a typical 10/4 pair whose exact disable and re-enable edges are probed one lookup either side. Random phases with biased hit rates then sweep the enable through many falls and rises while the configuration pins are toggled to show they are ignored.

// File: rtl/reuse_monitor_pkg.sv
package reuse_monitor_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/reuse_sat_counter.sv
module reuse_sat_counter
  import reuse_monitor_pkg::*;
#(
  parameter int W    = 5,
  parameter int INIT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  step_e        step,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] BOOT = W'(INIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= BOOT;
    end else begin
      unique case (step)
        STEP_UP:   if (cnt_q != TOP)      cnt_q <= cnt_q + 1'b1;
        STEP_DOWN: if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt = cnt_q;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step) == STEP_UP && $past(cnt_q) != TOP) |-> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step) == STEP_DOWN && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step) == STEP_UP && $past(cnt_q) == TOP) |-> cnt_q == TOP);
  // R5
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step) == STEP_DOWN && $past(cnt_q) == '0) |-> cnt_q == '0);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step) == STEP_HOLD) |-> $stable(cnt_q));
endmodule

// File: rtl/reuse_hyst_gate.sv
module reuse_hyst_gate #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] thr_in,
  input  logic [W-1:0] hyst_in,
  input  logic [W-1:0] cnt,
  output logic         en
);
  localparam int SW = W + 1;

  logic [W-1:0]  thr_q;
  logic [W-1:0]  hyst_q;
  logic [SW-1:0] rise_lvl;
  logic          below;
  logic          above;
  logic          en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q  <= thr_in;
      hyst_q <= hyst_in;
    end
  end

  assign rise_lvl = {1'b0, thr_q} + {1'b0, hyst_q};
  assign below    = cnt < thr_q;
  assign above    = {1'b0, cnt} >= rise_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)               en_q <= 1'b1;
    else if (en_q && below)   en_q <= 1'b0;
    else if (!en_q && above)  en_q <= 1'b1;
  end

  assign en = en_q;

  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(en_q)) |-> $past(cnt) < thr_q);
  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(en_q)) |-> {1'b0, $past(cnt)} >= rise_lvl);
  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(thr_q) && $stable(hyst_q)));
endmodule

// File: rtl/reuse_monitor.sv
module reuse_monitor
  import reuse_monitor_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_vld,
  input  logic             lp_hit,
  input  logic [CNT_W-1:0] thr_cfg,
  input  logic [CNT_W-1:0] hyst_cfg,
  output logic             mig_en
);
  localparam int MID = 1 << (CNT_W - 1);

  step_e            step;
  logic [CNT_W-1:0] reuse_cnt;

  always_comb begin
    if (!lookup_vld) step = STEP_HOLD;
    else if (lp_hit) step = STEP_UP;
    else             step = STEP_DOWN;
  end

  reuse_sat_counter #(.W(CNT_W), .INIT(MID)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .cnt   (reuse_cnt)
  );

  reuse_hyst_gate #(.W(CNT_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .thr_in  (thr_cfg),
    .hyst_in (hyst_cfg),
    .cnt     (reuse_cnt),
    .en      (mig_en)
  );

  // R8
  count_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !mig_en && lookup_vld && !lp_hit && reuse_cnt != '0) |=> reuse_cnt != $past(reuse_cnt));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (mig_en && reuse_cnt == CNT_W'(MID)));
endmodule

// File: tb/reuse_monitor_tb.sv
module reuse_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lookup_vld = 1'b0;
  logic         lp_hit = 1'b0;
  logic [W-1:0] thr_cfg = '0;
  logic [W-1:0] hyst_cfg = '0;
  logic         mig_en;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt, m_thr, m_hys;
  bit m_en;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reuse_monitor #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .lp_hit(lp_hit),
    .thr_cfg(thr_cfg), .hyst_cfg(hyst_cfg), .mig_en(mig_en)
  );

  function automatic int nxt_cnt(int c, bit v, bit h);
    if (!v) return c;
    if (h) return (c >= 31) ? 31 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic bit nxt_en(bit e, int c, int thr, int hys);
    if (e && c < thr) return 1'b0;
    if (!e && c >= thr + hys) return 1'b1;
    return e;
  endfunction

  task automatic check(string tag, bit exp);
    n_chk++;
    if (mig_en !== exp) begin
      n_bad++;
      $display("FAIL %s: mig_en=%0b expected %0b (model count %0d)", tag, mig_en, exp, m_cnt);
    end
  endtask

  task automatic do_reset(int thr, int hys);
    @(negedge clk);
    rst_n = 1'b0; lookup_vld = 1'b0;
    thr_cfg = W'(thr); hyst_cfg = W'(hys);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 16; m_en = 1'b1; m_thr = thr; m_hys = hys;
    check("R1 reset", 1'b1);
  endtask

  task automatic step(bit v, bit h);
    lookup_vld = v; lp_hit = h;
    @(posedge clk);
    m_en = nxt_en(m_en, m_cnt, m_thr, m_hys);
    m_cnt = nxt_cnt(m_cnt, v, h);
    @(negedge clk);
  endtask

  task automatic run(int n, bit v, bit h);
    for (int i = 0; i < n; i++) step(v, h);
  endtask

  task automatic settle();
    step(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    do_reset(10, 4);
    // R3 / R6: 6 misses bring 16 to 10, still not below 10
    run(6, 1'b1, 1'b0); settle();
    check("R6 at threshold stays on", 1'b1);
    // R10: idle cycles and lp_hit without strobe change nothing
    run(5, 1'b0, 1'b1); settle();
    check("R10 idle hold", 1'b1);
    run(1, 1'b1, 1'b0);
    check("R6 same edge as drop not yet", 1'b1);
    settle();
    check("R6 disable one edge later", 1'b0);
    // R8 / R2: 4 hits take 9 to 13, below 14
    run(4, 1'b1, 1'b1); settle();
    check("R7 below rise level", 1'b0);
    run(1, 1'b1, 1'b1); settle();
    check("R7 re-enable at thr+hyst", 1'b1);
    // R4: saturate at 31, then 21 misses reach 10 (on), 22 reach 9 (off)
    run(40, 1'b1, 1'b1);
    run(21, 1'b1, 1'b0); settle();
    check("R4 top saturation", 1'b1);
    run(1, 1'b1, 1'b0); settle();
    check("R4 top saturation drop", 1'b0);
    // R5: floor at 0, 13 hits reach 13 (off), 14 reach 14 (on)
    run(40, 1'b1, 1'b0);
    run(13, 1'b1, 1'b1); settle();
    check("R5 floor saturation", 1'b0);
    run(1, 1'b1, 1'b1); settle();
    check("R5 floor saturation rise", 1'b1);
    // R9: config pins moved after reset have no effect
    thr_cfg = 5'd31; hyst_cfg = 5'd0;
    run(3, 1'b1, 1'b0); settle();
    check("R9 cfg ignored", m_en);
    // zero threshold never disables
    do_reset(0, 0);
    run(40, 1'b1, 1'b0); settle();
    check("R6 zero threshold", 1'b1);
    // sum above 31 never re-enables
    do_reset(20, 15);
    run(5, 1'b1, 1'b0); settle();
    check("R6 drop with big margin", 1'b0);
    run(40, 1'b1, 1'b1); settle();
    check("R7 unreachable rise level", 1'b0);
    // random phases
    for (int p = 0; p < 6; p++) begin
      do_reset(int'($urandom_range(4, 24)), int'($urandom_range(0, 8)));
      for (int i = 0; i < 600; i++) begin
        int bias = ((i / 50) % 2 == 0) ? 30 : 75;
        bit v = ($urandom_range(0, 99) < 85);
        bit h = (int'($urandom_range(0, 99)) < bias);
        if ($urandom_range(0, 19) == 0) begin
          thr_cfg = W'($urandom); hyst_cfg = W'($urandom);
        end
        step(v, h);
        check("R2 R3 R6 R7 R8 R9 random", m_en);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule